// File: doc/BRIEF.md
# Rotate and Mask Unit

This block is a purely combinational datapath unit for a 64-bit integer pipeline. It rotates a source operand left and then keeps only the bits that fall inside a contiguous mask. Mask bits are numbered from the most significant end, so position 0 is the MSB. The rotate count comes either from a 6-bit immediate or from the low bits of a register operand. The mask is described by a start and a stop position, and the mask wraps around when the start lies after the stop.

Two insert operations merge the masked, rotated value into a prior destination value, which supplies every bit outside the mask. A word mode copies the low 32-bit half into both halves before the rotate and moves the mask positions into the low word. When recording is enabled, a 3-bit condition code classifies the signed result. The surrounding pipeline supplies the operands and consumes the result in the same cycle.

Top module: `rotmask_unit`

## Requirements
- R1: With op_sel 0, the result is the source rotated left by the count, ANDed with a mask that covers MSB-numbered positions mask_beg through mask_end when mask_beg <= mask_end. Position p is LSB index 63-p.
- R2: When mask_beg > mask_end, the mask covers positions mask_beg..63 together with positions 0..mask_end.
- R3: With op_sel 1 (insert), the result is (rotated AND mask) OR (old_val AND NOT mask).
- R4: When amt_sel is 1, the rotate count is amt_reg[5:0] and the upper bits of amt_reg have no effect. When amt_sel is 0, the count is amt_imm.
- R5: When word_mode is 1, the rotate input is {src_val[31:0], src_val[31:0]} and bit 5 of both mask_beg and mask_end is forced to 1 before the operation adjusts them.
- R6: With op_sel 2 (clear-left), the mask runs from mask_beg to 63 and mask_end is ignored.
- R7: With op_sel 3 (clear-right), the mask runs from 0 to mask_end and mask_beg is ignored.
- R8: With op_sel 4, the mask runs from mask_beg to the 6-bit complement of the rotate count. op_sel 5 is the insert form of the same mask.
- R9: When rec_en is 1, cr_code is 3'b100 for a negative signed result, 3'b010 for a positive result and 3'b001 for zero. When rec_en is 0, cr_code is 3'b000.
- R10: op_sel values 6 and 7 behave exactly like op_sel 0.
- R11: old_val has no effect on the result for any op_sel other than 1 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val | input | 64 | Operand to rotate |
| old_val | input | 64 | Prior destination value, used by the insert operations |
| amt_imm | input | 6 | Immediate rotate count |
| amt_reg | input | 64 | Register operand holding a rotate count in its low 6 bits |
| amt_sel | input | 1 | 1 selects amt_reg as the count source, 0 selects amt_imm |
| mask_beg | input | 6 | First mask position, MSB-numbered |
| mask_end | input | 6 | Last mask position, MSB-numbered |
| word_mode | input | 1 | Selects 32-bit word operation |
| op_sel | input | 3 | Operation code (0 to 5, see the requirements) |
| rec_en | input | 1 | Enables the condition code output |
| result | output | 64 | Rotated, masked and optionally merged value |
| cr_code | output | 3 | Condition code: {negative, positive, zero} |

## Verification
The unit holds no state, so any internal fault appears at the ports within the same evaluation as the inputs that expose it. A wrong rotate shows up as bits displaced in the result. A wrong mask bound or a wrong wrap decision shows up as extra or missing bits at the mask edges, so the stimulus places mask edges at positions 0, 63 and across the wrap point. A faulty merge leaks old_val bits into non-insert results or drops them from insert results. Both of these are exposed by varying old_val while the other inputs stay fixed.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
   typedef enum logic [2:0] {
      RM_ROTMASK   = 3'd0,
      RM_ROTINS    = 3'd1,
      RM_CLRLEFT   = 3'd2,
      RM_CLRRIGHT  = 3'd3,
      RM_CLRAMT    = 3'd4,
      RM_CLRAMTINS = 3'd5
   } rm_op_e;

   localparam int CR_W = 3;
   localparam int CR_NEG = 2;
   localparam int CR_POS = 1;
   localparam int CR_ZERO = 0;
endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN),
   localparam int HALF = XLEN / 2
) (
   input  logic [XLEN-1:0] src,
   input  logic            word_mode,
   input  logic [SHW-1:0]  amt,
   output logic [XLEN-1:0] rot
);
   logic [XLEN-1:0]   pre;
   logic [2*XLEN-1:0] dbl;

   always_comb begin
      pre = word_mode ? {src[HALF-1:0], src[HALF-1:0]} : src;
      dbl = {pre, pre} << amt;
      rot = dbl[2*XLEN-1:XLEN];
   end
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN)
) (
   input  logic [SHW-1:0]  first_pos,
   input  logic [SHW-1:0]  last_pos,
   output logic [XLEN-1:0] mask
);
   logic wraps;
   assign wraps = first_pos > last_pos;

   for (genvar p = 0; p < XLEN; p++) begin : g_pos
      localparam logic [SHW-1:0] POS = SHW'(p);
      logic ge_first, le_last;
      assign ge_first = POS >= first_pos;
      assign le_last  = POS <= last_pos;
      assign mask[XLEN-1-p] = wraps ? (ge_first | le_last) : (ge_first & le_last);
   end
endmodule

// File: rtl/rotmask_merge.sv
module rotmask_merge
   import rotmask_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] rot,
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] mask,
   input  logic            insert,
   input  logic            rec_en,
   output logic [XLEN-1:0] result,
   output logic [CR_W-1:0] cr_code
);
   logic [XLEN-1:0] keep;

   always_comb begin
      keep   = insert ? (old_val & ~mask) : '0;
      result = (rot & mask) | keep;
      cr_code = '0;
      if (rec_en) begin
         if (result == '0)          cr_code[CR_ZERO] = 1'b1;
         else if (result[XLEN-1])   cr_code[CR_NEG]  = 1'b1;
         else                       cr_code[CR_POS]  = 1'b1;
      end
   end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
   import rotmask_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] src_val,
   input  logic [XLEN-1:0] old_val,
   input  logic [SHW-1:0]  amt_imm,
   input  logic [XLEN-1:0] amt_reg,
   input  logic            amt_sel,
   input  logic [SHW-1:0]  mask_beg,
   input  logic [SHW-1:0]  mask_end,
   input  logic            word_mode,
   input  logic [2:0]      op_sel,
   input  logic            rec_en,
   output logic [XLEN-1:0] result,
   output logic [CR_W-1:0] cr_code
);
   initial begin
      assert (XLEN >= 8 && (XLEN & (XLEN - 1)) == 0)
         else $error("rotmask_unit: XLEN must be a power of two of at least 8");
   end

   logic [SHW-1:0]  amt;
   logic [SHW-1:0]  beg_w, end_w, first_pos, last_pos;
   logic [XLEN-1:0] rot, mask;
   logic            insert;
   rm_op_e          op;

   always_comb begin
      op    = rm_op_e'(op_sel);
      amt   = amt_sel ? amt_reg[SHW-1:0] : amt_imm;
      beg_w = mask_beg;
      end_w = mask_end;
      if (word_mode) begin
         beg_w[SHW-1] = 1'b1;
         end_w[SHW-1] = 1'b1;
      end
      first_pos = beg_w;
      last_pos  = end_w;
      insert    = 1'b0;
      case (op)
         RM_ROTINS:    insert = 1'b1;
         RM_CLRLEFT:   last_pos = '1;
         RM_CLRRIGHT:  first_pos = '0;
         RM_CLRAMT:    last_pos = ~amt;
         RM_CLRAMTINS: begin
            last_pos = ~amt;
            insert   = 1'b1;
         end
         default: ;
      endcase
   end

   rotmask_rotator #(.XLEN(XLEN)) rot_i (
      .src(src_val), .word_mode(word_mode), .amt(amt), .rot(rot)
   );

   rotmask_maskgen #(.XLEN(XLEN)) mask_i (
      .first_pos(first_pos), .last_pos(last_pos), .mask(mask)
   );

   rotmask_merge #(.XLEN(XLEN)) merge_i (
      .rot(rot), .old_val(old_val), .mask(mask), .insert(insert),
      .rec_en(rec_en), .result(result), .cr_code(cr_code)
   );
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN)
) (
   input logic [XLEN-1:0] old_val,
   input logic [SHW-1:0]  mask_beg,
   input logic [SHW-1:0]  mask_end,
   input logic [2:0]      op_sel,
   input logic            rec_en,
   input logic [XLEN-1:0] result,
   input logic [2:0]      cr_code
);
   always_comb begin
      // R9: one class bit when recording, none otherwise
      p_cr_onehot_r9: assert (rec_en ? $onehot(cr_code) : (cr_code == 3'b000))
         else $error("p_cr_onehot_r9");
      // R9: a negative result must be flagged negative
      p_cr_sign_r9: assert (!(rec_en && result[XLEN-1]) || cr_code == 3'b100)
         else $error("p_cr_sign_r9");
      // R3: insert with a one-position mask changes at most one bit of old_val
      p_insert_single_r3: assert (!(op_sel == 3'd1 && mask_beg == mask_end)
                                  || $countones(result ^ old_val) <= 1)
         else $error("p_insert_single_r3");
      // R1: a one-position mask keeps at most one bit
      p_single_bit_r1: assert (!(op_sel == 3'd0 && mask_beg == mask_end)
                               || $countones(result) <= 1)
         else $error("p_single_bit_r1");
   end
endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN)) chk_i (
   .old_val(old_val), .mask_beg(mask_beg), .mask_end(mask_end),
   .op_sel(op_sel), .rec_en(rec_en), .result(result), .cr_code(cr_code)
);

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [63:0] src_val, old_val, amt_reg, result;
   logic [5:0]  amt_imm, mask_beg, mask_end;
   logic        amt_sel, word_mode, rec_en;
   logic [2:0]  op_sel, cr_code;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   rotmask_unit dut_i (
      .src_val(src_val), .old_val(old_val), .amt_imm(amt_imm), .amt_reg(amt_reg),
      .amt_sel(amt_sel), .mask_beg(mask_beg), .mask_end(mask_end),
      .word_mode(word_mode), .op_sel(op_sel), .rec_en(rec_en),
      .result(result), .cr_code(cr_code)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic        wm;
      logic        sel;
      logic [5:0]  imm;
      logic [63:0] amt;
      logic [5:0]  beg;
      logic [5:0]  fin;
      logic [63:0] src;
      logic [63:0] old;
      logic [63:0] exp;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{3'd0, 1'b0, 1'b0, 6'd8, 64'd0, 6'd0,  6'd63, 64'h0123456789ABCDEF, 64'd0, 64'h23456789ABCDEF01},
      '{3'd0, 1'b0, 1'b0, 6'd0, 64'd0, 6'd0,  6'd0,  64'hFFFFFFFFFFFFFFFF, 64'd0, 64'h8000000000000000},
      '{3'd0, 1'b0, 1'b0, 6'd0, 64'd0, 6'd62, 6'd1,  64'hFFFFFFFFFFFFFFFF, 64'd0, 64'hC000000000000003},
      '{3'd1, 1'b0, 1'b0, 6'd4, 64'd0, 6'd56, 6'd63, 64'h000000000000000F, 64'hAAAAAAAAAAAAAAAA, 64'hAAAAAAAAAAAAAAF0},
      '{3'd0, 1'b1, 1'b0, 6'd1, 64'd0, 6'd0,  6'd31, 64'hFFFFFFFF80000001, 64'd0, 64'h0000000000000003},
      '{3'd2, 1'b0, 1'b0, 6'd0, 64'd0, 6'd60, 6'd5,  64'hFFFFFFFFFFFFFFFF, 64'd0, 64'h000000000000000F},
      '{3'd3, 1'b0, 1'b0, 6'd0, 64'd0, 6'd40, 6'd3,  64'hFFFFFFFFFFFFFFFF, 64'd0, 64'hF000000000000000},
      '{3'd4, 1'b0, 1'b1, 6'd0, 64'hFFFFFFFFFFFFFFC4, 6'd0, 6'd9, 64'h000000000000000F, 64'd0, 64'h00000000000000F0},
      '{3'd5, 1'b0, 1'b0, 6'd8, 64'd0, 6'd0,  6'd9,  64'h00000000000000FF, 64'h1234567890ABCDEF, 64'h000000000000FFEF},
      '{3'd6, 1'b0, 1'b0, 6'd8, 64'd0, 6'd0,  6'd63, 64'h0123456789ABCDEF, 64'd0, 64'h23456789ABCDEF01}
   };
   localparam string TAG [NV] = '{"R1", "R1", "R2", "R3", "R5", "R6", "R7", "R4 R8", "R8", "R10"};

   // Behavioural model written from the requirements
   function automatic logic [63:0] model(input logic [2:0] op, input logic wm, input logic sel,
                                         input logic [5:0] imm, input logic [63:0] amt,
                                         input logic [5:0] beg, input logic [5:0] fin,
                                         input logic [63:0] src, input logic [63:0] old);
      logic [5:0]  s, b, e;
      logic [63:0] x, r, m;
      s = sel ? amt[5:0] : imm;
      x = wm ? {src[31:0], src[31:0]} : src;
      for (int i = 0; i < 64; i++) r[(i + int'(s)) % 64] = x[i];
      b = beg; e = fin;
      if (wm) begin b[5] = 1'b1; e[5] = 1'b1; end
      if (op == 3'd2) e = 6'd63;
      if (op == 3'd3) b = 6'd0;
      if (op == 3'd4 || op == 3'd5) e = ~s;
      for (int p = 0; p < 64; p++)
         m[63-p] = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
      if (op == 3'd1 || op == 3'd5) return (r & m) | (old & ~m);
      return r & m;
   endfunction

   function automatic logic [2:0] cr_model(input logic [63:0] v, input logic en);
      if (!en) return 3'b000;
      if (v == 64'd0) return 3'b001;
      if ($signed(v) < 0) return 3'b100;
      return 3'b010;
   endfunction

   task automatic drive(input logic [2:0] op, input logic wm, input logic sel,
                        input logic [5:0] imm, input logic [63:0] amt,
                        input logic [5:0] beg, input logic [5:0] fin,
                        input logic [63:0] src, input logic [63:0] old, input logic rec);
      @(negedge clk);
      op_sel = op; word_mode = wm; amt_sel = sel; amt_imm = imm; amt_reg = amt;
      mask_beg = beg; mask_end = fin; src_val = src; old_val = old; rec_en = rec;
      #2;
   endtask

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: result actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: cr_code actual %b expected %b", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] r_a;
      // Idle state: all inputs zero gives zero and no recording (R9)
      drive(3'd0, 1'b0, 1'b0, 6'd0, 64'd0, 6'd0, 6'd0, 64'd0, 64'd0, 1'b0);
      check64("R1", result, 64'd0);
      check3("R9", cr_code, 3'b000);

      // Table walk
      for (int k = 0; k < NV; k++) begin
         drive(TBL[k].op, TBL[k].wm, TBL[k].sel, TBL[k].imm, TBL[k].amt, TBL[k].beg,
               TBL[k].fin, TBL[k].src, TBL[k].old, 1'b0);
         check64(TAG[k], result, TBL[k].exp);
      end

      // R9: condition codes
      drive(3'd0, 1'b0, 1'b0, 6'd0, 64'd0, 6'd0, 6'd0, 64'hFFFFFFFFFFFFFFFF, 64'd0, 1'b1);
      check3("R9 negative", cr_code, 3'b100);
      drive(3'd0, 1'b0, 1'b0, 6'd0, 64'd0, 6'd63, 6'd63, 64'd1, 64'd0, 1'b1);
      check3("R9 positive", cr_code, 3'b010);
      drive(3'd0, 1'b0, 1'b0, 6'd0, 64'd0, 6'd0, 6'd62, 64'd1, 64'd0, 1'b1);
      check3("R9 zero", cr_code, 3'b001);

      // R11: old_val ignored outside insert
      drive(3'd0, 1'b0, 1'b0, 6'd13, 64'd0, 6'd50, 6'd9, 64'h0F1E2D3C4B5A6978, 64'd0, 1'b0);
      r_a = result;
      drive(3'd0, 1'b0, 1'b0, 6'd13, 64'd0, 6'd50, 6'd9, 64'h0F1E2D3C4B5A6978, 64'hFFFFFFFFFFFFFFFF, 1'b0);
      check64("R11", result, r_a);

      // R4: upper bits of amt_reg ignored
      drive(3'd0, 1'b0, 1'b1, 6'd0, 64'h0000000000000007, 6'd0, 6'd63, 64'h8000000000000001, 64'd0, 1'b0);
      r_a = result;
      drive(3'd0, 1'b0, 1'b1, 6'd0, 64'hABCDEF0123456787, 6'd0, 6'd63, 64'h8000000000000001, 64'd0, 1'b0);
      check64("R4", result, r_a);
      check64("R4", result, 64'h00000000000000C0);

      // Random sweep against the model (R1 R2 R3 R5 R6 R7 R8 R10 R9)
      for (int n = 0; n < 400; n++) begin
         logic [2:0]  op;
         logic        wm, sel, rec;
         logic [5:0]  imm, beg, fin;
         logic [63:0] amt, src, old;
         op = 3'($urandom); wm = 1'($urandom); sel = 1'($urandom); rec = 1'($urandom);
         imm = 6'($urandom); beg = 6'($urandom); fin = 6'($urandom);
         amt = {$urandom, $urandom}; src = {$urandom, $urandom}; old = {$urandom, $urandom};
         drive(op, wm, sel, imm, amt, beg, fin, src, old, rec);
         check64("R1-random", result, model(op, wm, sel, imm, amt, beg, fin, src, old));
         check3("R9-random", cr_code, cr_model(model(op, wm, sel, imm, amt, beg, fin, src, old), rec));
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule